// File: doc/BRIEF.md
# Stack-Relative Data Move Engine

This block executes the data-memory move operations of a small processor core whose data space is 4096 bytes. A move takes two instruction words. The first word carries a 7-bit source offset. The source byte sits at the software stack pointer plus that offset. The second word names the destination in one of two ways: as a 12-bit absolute address, or as a second 7-bit offset from the same stack pointer. The block also executes a one-word push of an 8-bit literal. The push stores the literal at the stack pointer and hands back the stack pointer decremented by one.

The core's fetch logic presents instruction words one at a time, each with a valid strobe, and gaps between words are allowed. The current stack pointer value comes in as an input. The block reads the source byte through an asynchronous read port during the first-word cycle. It issues its result on a registered write port in the cycle after the word that completes the operation, together with a stack pointer update for pushes.

Some addresses get special treatment. Reads from the indirect-access register window return 00h. A relative destination that falls in that window cancels the write. Writes to the program-counter-low and return-stack byte locations are always dropped. All address sums wrap modulo 4096.

Top module: `smv_engine`

## Requirements
- R1: While reset is asserted, and until the first word is accepted after reset, `wr_en`, `ptr2_load` and `rd_en` are 0.
- R2: First word 1110_1011_0 followed by offset bits [6:0] (hex EB00-EB7F), then second word with bits [15:12]=1111 and absolute address in bits [11:0]. The byte read at `ptr2`+offset appears on `wr_data`, with `wr_addr` set to the absolute address and `wr_en`=1, in the cycle after the second word is accepted.
- R3: First word 1110_1011_1 followed by offset bits [6:0] (hex EB80-EBFF), then second word with bits [15:12]=1111 and destination offset in bits [6:0]. The write goes to `ptr2` (as sampled with the second word) plus that offset. Bits [11:7] of the second word are ignored.
- R4: A source address inside the indirect window (defaults FEBh-FEFh, FE3h-FE7h, FDBh-FDFh) yields `wr_data`=00h whatever the memory returns.
- R5: For the relative-destination form, a destination inside the indirect window produces no write.
- R6: For the absolute-destination form, a destination inside the indirect window is written normally.
- R7: A destination of FF9h, FFDh, FFEh or FFFh produces no write in either form. The operation still completes, and the next word is treated as a new first word.
- R8: Word 1111_1010 followed by the literal k in bits [7:0] (hex FAkk), accepted as a first word, gives `wr_en`=1, `wr_addr`=`ptr2`, `wr_data`=k, `ptr2_load`=1 and `ptr2_value`=`ptr2`-1 (mod 4096) in the next cycle, all for one cycle.
- R9: Source and destination address sums wrap modulo 4096.
- R10: Any other word accepted as a first word causes neither a write nor a pointer load. Cycles with `instr_valid`=0 change nothing, including between the two words of a move.
- R11: A second word whose bits [15:12] are not 1111 cancels the pending move without a write.
- R12: `rd_en` is 1 exactly in a cycle where a move first word is valid and no move is pending, with `rd_addr`=`ptr2`+offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| ptr2 | input | 12 | Current software stack pointer |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 12 | Source read address |
| rd_data | input | 8 | Source read data (same cycle) |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 12 | Destination write address |
| wr_data | output | 8 | Destination write data |
| ptr2_load | output | 1 | Stack pointer update strobe |
| ptr2_value | output | 12 | New stack pointer value |

## Verification
The only internal state is the pending-move flag, the remembered destination form and the captured source byte. A fault in any of them shows at the write port one cycle after the second word. The symptoms are a write that is missing or spurious, a write to an absolute address where a relative one was due or the reverse, or the wrong data byte. A stuck pending flag also shows at once on the next first word: a push is then taken as a second word, and `rd_en` stays low for a move. Each of these is visible within two cycles of the word that exposes it.

// File: rtl/smv_pkg.sv
package smv_pkg;
  localparam int IW = 16;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_MOVE_ABS = 2'd1,
    OP_MOVE_REL = 2'd2,
    OP_PUSH     = 2'd3
  } op_e;

  localparam logic [7:0] MOVE_HI  = 8'hEB;
  localparam logic [7:0] PUSH_HI  = 8'hFA;
  localparam logic [3:0] TAIL_HI  = 4'hF;
endpackage

// File: rtl/smv_decode.sv
module smv_decode
  import smv_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int OFS_W = 7
) (
  input  logic [IW-1:0]    word,
  output op_e              op,
  output logic             is_tail,
  output logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    abs_dst,
  output logic [DW-1:0]    lit
);
  always_comb begin
    op = OP_NONE;
    if (word[15:8] == MOVE_HI) begin
      op = word[7] ? OP_MOVE_REL : OP_MOVE_ABS;
    end else if (word[15:8] == PUSH_HI) begin
      op = OP_PUSH;
    end
  end

  assign is_tail = (word[15:12] == TAIL_HI);
  assign ofs     = word[OFS_W-1:0];
  assign abs_dst = word[AW-1:0];
  assign lit     = word[DW-1:0];
endmodule

// File: rtl/smv_ind_match.sv
module smv_ind_match #(
  parameter int                   AW     = 12,
  parameter int                   GROUPS = 3,
  parameter int                   SPAN   = 5,
  parameter logic [GROUPS*AW-1:0] TOPS   = {12'hFDF, 12'hFE7, 12'hFEF}
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [GROUPS-1:0] g_hit;

  for (genvar g = 0; g < GROUPS; g++) begin : g_win
    localparam logic [AW-1:0] TOP = TOPS[g*AW +: AW];
    localparam logic [AW-1:0] LOW = TOP - AW'(SPAN);
    assign g_hit[g] = (addr <= TOP) && (addr > LOW);
  end

  assign hit = |g_hit;
endmodule

// File: rtl/smv_prot_match.sv
module smv_prot_match #(
  parameter int                AW   = 12,
  parameter int                NUM  = 4,
  parameter logic [NUM*AW-1:0] LIST = {12'hFFF, 12'hFFE, 12'hFFD, 12'hFF9}
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NUM-1:0] e_hit;

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    assign e_hit[i] = (addr == LIST[i*AW +: AW]);
  end

  assign hit = |e_hit;
endmodule

// File: rtl/smv_engine.sv
module smv_engine
  import smv_pkg::*;
#(
  parameter int                       AW         = 12,
  parameter int                       DW         = 8,
  parameter int                       OFS_W      = 7,
  parameter int                       IND_GROUPS = 3,
  parameter int                       IND_SPAN   = 5,
  parameter logic [IND_GROUPS*AW-1:0] IND_TOPS   = {12'hFDF, 12'hFE7, 12'hFEF},
  parameter int                       PROT_N     = 4,
  parameter logic [PROT_N*AW-1:0]     PROT_LIST  = {12'hFFF, 12'hFFE, 12'hFFD, 12'hFF9}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr_word,
  input  logic [AW-1:0] ptr2,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ptr2_load,
  output logic [AW-1:0] ptr2_value
);
  localparam int PAD = AW - OFS_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // decode
  op_e              op;
  logic             is_tail;
  logic [OFS_W-1:0] ofs;
  logic [AW-1:0]    abs_dst;
  logic [DW-1:0]    lit;

  smv_decode #(.AW(AW), .DW(DW), .OFS_W(OFS_W)) u_dec (
    .word(instr_word), .op(op), .is_tail(is_tail),
    .ofs(ofs), .abs_dst(abs_dst), .lit(lit)
  );

  // state
  logic          pending_q, pending_d;
  logic          rel_q, rel_d;
  logic [DW-1:0] src_q, src_d;
  logic          wr_en_q, wr_en_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [DW-1:0] wr_data_q, wr_data_d;
  logic          load_q, load_d;
  logic [AW-1:0] pval_q, pval_d;

  // address paths
  logic [AW-1:0] rel_addr, dst_addr;
  logic          src_ind, dst_ind, dst_prot;

  assign rel_addr = ptr2 + {{PAD{1'b0}}, ofs};
  assign dst_addr = rel_q ? rel_addr : abs_dst;

  smv_ind_match #(.AW(AW), .GROUPS(IND_GROUPS), .SPAN(IND_SPAN), .TOPS(IND_TOPS)) u_src_ind (
    .addr(rel_addr), .hit(src_ind)
  );
  smv_ind_match #(.AW(AW), .GROUPS(IND_GROUPS), .SPAN(IND_SPAN), .TOPS(IND_TOPS)) u_dst_ind (
    .addr(dst_addr), .hit(dst_ind)
  );
  smv_prot_match #(.AW(AW), .NUM(PROT_N), .LIST(PROT_LIST)) u_dst_prot (
    .addr(dst_addr), .hit(dst_prot)
  );

  logic first_ok, take_first, take_second;
  assign first_ok    = (op == OP_MOVE_ABS) || (op == OP_MOVE_REL);
  assign take_first  = instr_valid && !pending_q;
  assign take_second = instr_valid && pending_q;

  assign rd_en   = take_first && first_ok;
  assign rd_addr = rel_addr;

  // next state
  always_comb begin
    pending_d = pending_q;
    rel_d     = rel_q;
    src_d     = src_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    load_d    = 1'b0;
    pval_d    = pval_q;
    if (take_first) begin
      if (first_ok) begin
        pending_d = 1'b1;
        rel_d     = (op == OP_MOVE_REL);
        src_d     = src_ind ? '0 : rd_data;
      end else if (op == OP_PUSH) begin
        wr_en_d   = 1'b1;
        wr_addr_d = ptr2;
        wr_data_d = lit;
        load_d    = 1'b1;
        pval_d    = ptr2 - AW'(1);
      end
    end else if (take_second) begin
      pending_d = 1'b0;
      if (is_tail) begin
        wr_en_d   = !dst_prot && !(rel_q && dst_ind);
        wr_addr_d = dst_addr;
        wr_data_d = src_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pending_q <= 1'b0;
      rel_q     <= 1'b0;
      src_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      load_q    <= 1'b0;
      pval_q    <= '0;
    end else begin
      pending_q <= pending_d;
      wr_en_q   <= wr_en_d;
      load_q    <= load_d;
      if (take_first && first_ok) begin
        rel_q <= rel_d;
        src_q <= src_d;
      end
      if (wr_en_d || take_second) begin
        wr_addr_q <= wr_addr_d;
        wr_data_q <= wr_data_d;
      end
      if (load_d) begin
        pval_q <= pval_d;
      end
    end
  end

  assign wr_en      = wr_en_q;
  assign wr_addr    = wr_addr_q;
  assign wr_data    = wr_data_q;
  assign ptr2_load  = load_q;
  assign ptr2_value = pval_q;
endmodule

// File: rtl/smv_engine_chk.sv
module smv_engine_chk #(
  parameter int                   AW        = 12,
  parameter int                   DW        = 8,
  parameter int                   PROT_N    = 4,
  parameter logic [PROT_N*AW-1:0] PROT_LIST = {12'hFFF, 12'hFFE, 12'hFFD, 12'hFF9}
) (
  input logic          clk,
  input logic          rst_q,
  input logic          pending_q,
  input logic          instr_valid,
  input logic [15:0]   instr_word,
  input logic [AW-1:0] ptr2,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          ptr2_load,
  input logic [AW-1:0] ptr2_value
);
  function automatic logic is_prot(input logic [AW-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < PROT_N; i++) begin
      if (a == PROT_LIST[i*AW +: AW]) r = 1'b1;
    end
    return r;
  endfunction

  logic push_take;
  assign push_take = instr_valid && !pending_q && (instr_word[15:8] == 8'hFA);

  assert_push_result_R8: assert property (@(posedge clk) disable iff (!rst_q)
    push_take |=> (wr_en && ptr2_load && wr_addr == $past(ptr2)
                   && wr_data == $past(instr_word[DW-1:0])
                   && ptr2_value == $past(ptr2) - AW'(1)));

  assert_load_with_write_R8: assert property (@(posedge clk) disable iff (!rst_q)
    ptr2_load |-> (wr_en && ptr2_value == wr_addr - AW'(1)));

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !instr_valid |=> (!wr_en && !ptr2_load));

  assert_no_protected_write_R7: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en |-> !is_prot(wr_addr));

  assert_bad_tail_cancel_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (pending_q && instr_valid && instr_word[15:12] != 4'hF) |=> !wr_en);

  assert_read_only_on_first_R12: assert property (@(posedge clk) disable iff (!rst_q)
    rd_en |-> (instr_valid && !pending_q));
endmodule

bind smv_engine smv_engine_chk #(
  .AW(AW), .DW(DW), .PROT_N(PROT_N), .PROT_LIST(PROT_LIST)
) u_chk (
  .clk(clk), .rst_q(rst_q), .pending_q(pending_q),
  .instr_valid(instr_valid), .instr_word(instr_word), .ptr2(ptr2),
  .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ptr2_load(ptr2_load), .ptr2_value(ptr2_value)
);

// File: tb/smv_engine_test.sv
module smv_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic [11:0] ptr2;
  logic        rd_en;
  logic [11:0] rd_addr;
  logic [7:0]  rd_data;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic        ptr2_load;
  logic [11:0] ptr2_value;

  logic [7:0] mem [4096];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign rd_data = mem[rd_addr];

  smv_engine uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .ptr2(ptr2), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr2_load(ptr2_load), .ptr2_value(ptr2_value)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = 16'h0000;
  endtask

  task automatic expect_write(input string tag, input logic [11:0] a, input logic [7:0] d);
    check({tag, " wr_en"}, wr_en, 1'b1);
    check({tag, " wr_addr"}, wr_addr, a);
    check({tag, " wr_data"}, wr_data, d);
    check({tag, " ptr2_load"}, ptr2_load, 1'b0);
  endtask

  task automatic expect_quiet(input string tag);
    check({tag, " wr_en"}, wr_en, 1'b0);
    check({tag, " ptr2_load"}, ptr2_load, 1'b0);
  endtask

  task automatic move(input logic [15:0] w1, input logic [15:0] w2);
    drive(w1);
    drive(w2);
    idle();
  endtask

  task automatic t_reset();
    check("R1 wr_en", wr_en, 1'b0);
    check("R1 ptr2_load", ptr2_load, 1'b0);
    check("R1 rd_en", rd_en, 1'b0);
  endtask

  task automatic t_abs_move();
    ptr2 = 12'h080; mem[12'h085] = 8'h33;
    drive(16'hEB05);
    #1;
    check("R12 rd_en first", rd_en, 1'b1);
    check("R12 rd_addr", rd_addr, 12'h085);
    drive(16'hF123);
    #1;
    check("R12 rd_en second", rd_en, 1'b0);
    idle();
    expect_write("R2 abs", 12'h123, 8'h33);
  endtask

  task automatic t_rel_move();
    ptr2 = 12'h080;
    move(16'hEB85, 16'hFF86);  // bits [11:7] of tail set: ignored
    expect_write("R3 rel", 12'h086, 8'h33);
  endtask

  task automatic t_wrap();
    ptr2 = 12'hFF0; mem[12'h06F] = 8'h5A;
    move(16'hEBFF, 16'hF020);
    expect_write("R9 wrap", 12'h010, 8'h5A);
  endtask

  task automatic t_ind_src();
    ptr2 = 12'hFE0; mem[12'hFEC] = 8'h77;
    move(16'hEB0C, 16'hF200);
    expect_write("R4 indirect source", 12'h200, 8'h00);
    ptr2 = 12'hFD0; mem[12'hFDA] = 8'h44;  // just below a window: real data
    move(16'hEB0A, 16'hF201);
    expect_write("R4 window edge", 12'h201, 8'h44);
  endtask

  task automatic t_ind_dst();
    ptr2 = 12'hFD0; mem[12'hFD1] = 8'h99;
    move(16'hEB81, 16'hF00F);
    expect_quiet("R5 rel indirect dest");
    move(16'hEB01, 16'hFFEE);
    expect_write("R6 abs indirect dest", 12'hFEE, 8'h99);
  endtask

  task automatic t_protected();
    ptr2 = 12'h080;
    move(16'hEB05, 16'hFFF9);
    expect_quiet("R7 abs protected");
    ptr2 = 12'hF90; mem[12'hF91] = 8'h12;
    move(16'hEB81, 16'hF06F);
    expect_quiet("R7 rel protected");
    ptr2 = 12'h1EC;
    drive(16'hFA01);
    idle();
    check("R7 next word fresh", wr_en, 1'b1);
    check("R7 next word load", ptr2_load, 1'b1);
  endtask

  task automatic t_push();
    ptr2 = 12'h1EC;
    drive(16'hFA08);
    idle();
    check("R8 wr_en", wr_en, 1'b1);
    check("R8 wr_addr", wr_addr, 12'h1EC);
    check("R8 wr_data", wr_data, 8'h08);
    check("R8 load", ptr2_load, 1'b1);
    check("R8 value", ptr2_value, 12'h1EB);
    idle();
    check("R8 single cycle", {31'd0, wr_en | ptr2_load}, 32'd0);
    ptr2 = 12'h000;
    drive(16'hFAC3);
    idle();
    check("R8 wrap value", ptr2_value, 12'hFFF);
    check("R8 wrap data", wr_data, 8'hC3);
  endtask

  task automatic t_other_and_gaps();
    ptr2 = 12'h080;
    drive(16'hE823);
    drive(16'h0014);
    drive(16'hF123);
    idle();
    expect_quiet("R10 other words");
    drive(16'hEB05);
    idle(); expect_quiet("R10 gap 1");
    idle(); expect_quiet("R10 gap 2");
    idle(); expect_quiet("R10 gap 3");
    drive(16'hF300);
    idle();
    expect_write("R10 after gap", 12'h300, 8'h33);
  endtask

  task automatic t_cancel();
    ptr2 = 12'h080;
    move(16'hEB05, 16'h0E12);
    expect_quiet("R11 cancel");
    move(16'hEB05, 16'hF055);
    expect_write("R11 recover", 12'h055, 8'h33);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hA5;
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = 16'h0; ptr2 = 12'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_abs_move();
    t_rel_move();
    t_wrap();
    t_ind_src();
    t_ind_dst();
    t_protected();
    t_push();
    t_other_and_gaps();
    t_cancel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule